// File: doc/BRIEF.md
# Cycle-Window Response Monitor

A synthesizable runtime monitor that watches a trigger line and a response line on every clock edge and reports when a timing obligation set up by a trigger is broken. Two parameters bound a window `WIN_LO` to `WIN_HI` cycles after each trigger. A per-trigger check mode decides which rule applies: the response at exactly offset `WIN_LO`, the response on every cycle of the window, or the response on at least one cycle of the window.

Every trigger opens its own obligation, which travels down an age pipeline `WIN_HI` stages deep. Obligations from back-to-back triggers overlap freely and are judged independently. When any live obligation fails on a cycle, the block raises a one-cycle error pulse on the following cycle and sets a sticky error flag that holds until reset. It is intended to sit beside a design block in silicon or emulation as an always-on protocol watchdog.

Top module: `window_resp_monitor`

## Requirements
- R1: The asynchronous active-low reset clears every pending obligation, the error pulse and the sticky flag; triggers seen while reset is low create no obligation.
- R2: A cycle with `trig_i` low creates no obligation, so with no triggers no error is ever raised whatever `resp_i` does.
- R3: With `mode_i` = 2'b00 on the trigger cycle, `resp_i` must be high exactly `WIN_LO` cycles after the trigger; otherwise `err_pulse_o` is high on the cycle after that one.
- R4: With `mode_i` = 2'b01 on the trigger cycle, `resp_i` must be high on every cycle from `WIN_LO` through `WIN_HI` cycles after the trigger; each cycle where it is low gives an error pulse on the next cycle.
- R5: With `mode_i` = 2'b10 on the trigger cycle, `resp_i` must be high on at least one cycle from `WIN_LO` through `WIN_HI` after the trigger; if not, the pulse comes on the cycle after offset `WIN_HI`.
- R6: Obligations of triggers on nearby cycles overlap and each is checked on its own.
- R7: In mode 2'b10 one response cycle inside several windows satisfies all of those triggers.
- R8: Response pulses on cycles that no obligation constrains never cause an error.
- R9: The mode is captured on the trigger cycle and kept with that obligation; later changes of `mode_i` do not alter it.
- R10: `err_sticky_o` rises together with the first error pulse and stays high until reset; several obligations failing on one cycle give one pulse.
- R11: `mode_i` = 2'b11 is checked as exact offset, like 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| trig_i | input | 1 | Trigger; high opens a new obligation |
| resp_i | input | 1 | Response being checked against open obligations |
| mode_i | input | 2 | Check mode sampled with the trigger: 00 exact, 01 all cycles, 10 any cycle, 11 exact |
| err_pulse_o | output | 1 | High for one cycle after a cycle with a failed obligation |
| err_sticky_o | output | 1 | Set with the first error, held until reset |

## Verification
A failure found on cycle c (the trigger cycle plus `WIN_LO` in exact mode, any window cycle in all-cycles mode, the trigger cycle plus `WIN_HI` in any-cycle mode) shows on `err_pulse_o` and `err_sticky_o` on cycle c+1, one register later. The bench drives each cycle's inputs at the falling edge, records them in a history, and one clock edge later samples both outputs and compares them with a value recomputed from that history for cycle c. The directed sequences place responses right at and just outside the window edges, so an off-by-one offset shows as a wrong-cycle pulse.

// File: rtl/wrm_pkg.sv
package wrm_pkg;

  // Check mode carried by each obligation (R3, R4, R5, R11)
  typedef enum logic [1:0] {
    CHK_EXACT     = 2'b00,
    CHK_ALL       = 2'b01,
    CHK_ANY       = 2'b10,
    CHK_EXACT_ALT = 2'b11
  } chk_mode_e;

  // One pending obligation at a given age
  typedef struct packed {
    logic      live;
    chk_mode_e mode;
    logic      met;
  } oblig_t;

endpackage

// File: rtl/wrm_stage_eval.sv
// Judges the obligation of one fixed age against the current response.
module wrm_stage_eval
  import wrm_pkg::*;
#(
  parameter int AGE    = 1,
  parameter int WIN_LO = 2,
  parameter int WIN_HI = 5
) (
  input  oblig_t ob_i,
  input  logic   resp_i,
  output logic   fail_o,
  output logic   met_fwd_o
);

  localparam bit IN_WIN = (AGE >= WIN_LO) && (AGE <= WIN_HI);
  localparam bit AT_LO  = (AGE == WIN_LO);
  localparam bit AT_HI  = (AGE == WIN_HI);

  logic hit;

  always_comb begin
    hit       = IN_WIN && resp_i;
    // R7: any in-window response marks this obligation met
    met_fwd_o = ob_i.met | hit;
    fail_o    = 1'b0;
    if (ob_i.live) begin
      unique case (ob_i.mode)
        CHK_EXACT, CHK_EXACT_ALT: fail_o = AT_LO && !resp_i;          // R3, R11
        CHK_ALL:                  fail_o = IN_WIN && !resp_i;         // R4
        CHK_ANY:                  fail_o = AT_HI && !(ob_i.met | hit); // R5
        default:                  fail_o = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/wrm_oblig_pipe.sv
// Age pipeline: entry g holds the obligation opened g+1 cycles ago.
module wrm_oblig_pipe
  import wrm_pkg::*;
#(
  parameter int DEPTH = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_i,
  input  logic [1:0] mode_i,
  input  logic       met_fwd_i [DEPTH],
  output oblig_t     stg_o     [DEPTH]
);

  oblig_t stg_q [DEPTH];
  oblig_t stg_d [DEPTH];
  logic   any_live;
  logic   shift_en;

  always_comb begin
    any_live = 1'b0;
    for (int i = 0; i < DEPTH; i++) any_live = any_live | stg_q[i].live;
    // clock enable: idle pipeline holds still
    shift_en = trig_i | any_live;
  end

  always_comb begin
    // R9: mode is captured with the trigger and travels with it
    stg_d[0].live = trig_i;
    stg_d[0].mode = chk_mode_e'(mode_i);
    stg_d[0].met  = 1'b0;
    for (int i = 1; i < DEPTH; i++) begin
      stg_d[i]     = stg_q[i-1];
      stg_d[i].met = met_fwd_i[i-1];
    end
  end

  // R1: reset empties every age slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= '{live: 1'b0, mode: CHK_EXACT, met: 1'b0};
    end else if (shift_en) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign stg_o = stg_q;

endmodule

// File: rtl/wrm_flag.sv
// Registers the per-cycle violation into a pulse and a sticky flag.
module wrm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic viol_i,
  output logic pulse_o,
  output logic sticky_o
);

  logic pulse_q, pulse_d;
  logic sticky_q, sticky_d;
  logic sticky_en;

  always_comb begin
    pulse_d   = viol_i;                 // R10: one pulse per failing cycle
    sticky_en = viol_i & ~sticky_q;
    sticky_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sticky_q <= 1'b0;
    else if (sticky_en) sticky_q <= sticky_d;
  end

  assign pulse_o  = pulse_q;
  assign sticky_o = sticky_q;

endmodule

// File: rtl/window_resp_monitor.sv
module window_resp_monitor
  import wrm_pkg::*;
#(
  parameter int WIN_LO = 2,
  parameter int WIN_HI = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_i,
  input  logic       resp_i,
  input  logic [1:0] mode_i,
  output logic       err_pulse_o,
  output logic       err_sticky_o
);

  localparam int DEPTH = WIN_HI;

  oblig_t stg     [DEPTH];
  logic   met_fwd [DEPTH];
  logic [DEPTH-1:0] fail_vec;
  logic   viol;

  wrm_oblig_pipe #(.DEPTH(DEPTH)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_i    (trig_i),
    .mode_i    (mode_i),
    .met_fwd_i (met_fwd),
    .stg_o     (stg)
  );

  // R6: one evaluator per age, all obligations judged in parallel
  for (genvar g = 0; g < DEPTH; g++) begin : g_age
    wrm_stage_eval #(.AGE(g + 1), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_eval (
      .ob_i      (stg[g]),
      .resp_i    (resp_i),
      .fail_o    (fail_vec[g]),
      .met_fwd_o (met_fwd[g])
    );
  end

  assign viol = |fail_vec;

  wrm_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .viol_i   (viol),
    .pulse_o  (err_pulse_o),
    .sticky_o (err_sticky_o)
  );

endmodule

// File: rtl/wrm_checker.sv
module wrm_checker #(
  parameter int WIN_LO = 2,
  parameter int WIN_HI = 5
) (
  input logic clk,
  input logic rst_n,
  input logic trig_i,
  input logic err_pulse_o,
  input logic err_sticky_o
);

  localparam int LIMIT = WIN_HI + 2;
  localparam int CW    = $clog2(LIMIT + 1) + 1;

  logic [CW-1:0] quiet_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     quiet_cnt <= CW'(LIMIT);
    else if (trig_i)                quiet_cnt <= '0;
    else if (quiet_cnt < CW'(LIMIT)) quiet_cnt <= quiet_cnt + 1'b1;
  end

  initial begin
    window_param_chk: assert (WIN_LO >= 1 && WIN_LO <= WIN_HI);
  end

  // R2
  no_orphan_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_cnt > CW'(WIN_HI)) |-> !err_pulse_o);

  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky_o |=> err_sticky_o);

  // R10
  pulse_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse_o |-> err_sticky_o);

  // R10
  sticky_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_sticky_o) |-> err_pulse_o);

endmodule

bind window_resp_monitor wrm_checker #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_wrm_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .trig_i       (trig_i),
  .err_pulse_o  (err_pulse_o),
  .err_sticky_o (err_sticky_o)
);

// File: tb/tb_window_resp_monitor.sv
`timescale 1ns/1ps
module tb_window_resp_monitor;

  localparam int LO   = 2;
  localparam int HI   = 5;
  localparam int MAXC = 8192;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig_i = 1'b0;
  logic       resp_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       err_pulse_o;
  logic       err_sticky_o;

  int  errors = 0;
  int  checks = 0;
  int  cyc = 0;
  bit  exp_sticky = 0;
  bit        h_trig [MAXC];
  bit  [1:0] h_mode [MAXC];
  bit        h_resp [MAXC];

  window_resp_monitor #(.WIN_LO(LO), .WIN_HI(HI)) dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .resp_i(resp_i),
    .mode_i(mode_i), .err_pulse_o(err_pulse_o), .err_sticky_o(err_sticky_o)
  );

  always #4 clk = ~clk;

  // expected failure on cycle c, derived from the mode rules
  function automatic bit viol(int c);
    bit v = 0;
    for (int k = 1; k <= HI; k++) begin
      int t = c - k;
      if (t >= 0 && h_trig[t]) begin
        case (h_mode[t])
          2'b01: if (k >= LO && !h_resp[c]) v = 1;
          2'b10: if (k == HI) begin
                   bit seen = 0;
                   for (int j = t + LO; j <= c; j++) seen |= h_resp[j];
                   if (!seen) v = 1;
                 end
          default: if (k == LO && !h_resp[c]) v = 1;
        endcase
      end
    end
    return v;
  endfunction

  task automatic check(bit act, bit exp, string tag, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: actual=%0b expected=%0b", tag, what, cyc, act, exp);
    end
  endtask

  task automatic step(bit t, bit r, bit [1:0] m, string tag);
    bit v;
    @(negedge clk);
    trig_i = t; resp_i = r; mode_i = m;
    h_trig[cyc] = t; h_resp[cyc] = r; h_mode[cyc] = m;
    @(posedge clk); #1;
    v = viol(cyc);
    exp_sticky |= v;
    check(err_pulse_o, v, tag, "pulse");
    check(err_sticky_o, exp_sticky, tag, "sticky");
    cyc++;
  endtask

  task automatic idle(int n, bit r, string tag);
    for (int i = 0; i < n; i++) step(0, r, 2'b00, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; trig_i = 1; resp_i = 0; mode_i = 2'b00;
    #1;
    // R1: outputs clear at once
    check(err_pulse_o, 0, "R1", "pulse in reset");
    check(err_sticky_o, 0, "R1", "sticky in reset");
    repeat (3) @(negedge clk);
    for (int i = 0; i < MAXC; i++) begin h_trig[i] = 0; h_resp[i] = 0; h_mode[i] = 0; end
    cyc = 0; exp_sticky = 0;
    rst_n = 1; trig_i = 0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R1: triggers held during reset leave nothing pending
    idle(HI + 3, 0, "R1");
    // R2: responses with no triggers
    for (int i = 0; i < 10; i++) step(0, $urandom % 2, 2'b00, "R2");
    // R3 pass, with stray responses outside the window (R8)
    step(1, 1, 2'b00, "R3"); step(0, 0, 2'b00, "R3"); step(0, 1, 2'b00, "R3");
    step(0, 0, 2'b00, "R8"); step(0, 1, 2'b00, "R8"); idle(3, 1, "R8");
    // R11 pass
    step(1, 0, 2'b11, "R11"); step(0, 0, 2'b00, "R11"); step(0, 1, 2'b00, "R11"); idle(4, 0, "R11");
    // R4 pass
    step(1, 0, 2'b01, "R4"); step(0, 0, 2'b01, "R4"); idle(4, 1, "R4"); idle(3, 0, "R4");
    // R5 pass, response at age 4 only
    step(1, 0, 2'b10, "R5"); idle(3, 0, "R5"); step(0, 1, 2'b10, "R5"); idle(3, 0, "R5");
    // R7: one response inside two any-mode windows
    step(1, 0, 2'b10, "R7"); step(0, 0, 2'b10, "R7"); step(1, 0, 2'b10, "R7");
    step(0, 0, 2'b10, "R7"); step(0, 1, 2'b10, "R7"); idle(5, 0, "R7");
    // R9: any-mode trigger, mode_i switched to exact during its window
    step(1, 0, 2'b10, "R9"); step(0, 0, 2'b00, "R9"); step(0, 0, 2'b00, "R9");
    step(0, 1, 2'b00, "R9"); idle(4, 0, "R9");
    // R3 fail: response missing at exact offset
    step(1, 1, 2'b00, "R3"); step(0, 1, 2'b00, "R3"); step(0, 0, 2'b00, "R3"); idle(3, 0, "R3");
    // R4 fail at two window cycles; R6 overlapping all-mode triggers
    step(1, 0, 2'b01, "R6"); step(1, 0, 2'b01, "R6"); step(0, 1, 2'b01, "R6");
    step(0, 0, 2'b01, "R4"); step(0, 1, 2'b01, "R6"); step(0, 0, 2'b01, "R4"); idle(4, 0, "R6");
    // R5 fail: no response at all
    step(1, 0, 2'b10, "R5"); idle(HI + 2, 0, "R5");
    // R10: sticky holds through quiet cycles
    idle(20, 0, "R10");
    // random traffic with overlapping obligations
    for (int i = 0; i < 2000; i++)
      step(($urandom % 4) == 0, ($urandom % 4) != 0, 2'($urandom % 4), "R6");
    idle(HI + 2, 0, "R6");
    // R1: mid-run reset clears sticky
    do_reset();
    idle(HI + 3, 0, "R1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule